// File: doc/BRIEF.md
# GPIO Port Register Bank

This block holds the software-visible state of a 32-pin general-purpose I/O port behind a small memory-mapped register interface. The interface has a byte address, 32-bit write data, single-cycle write and read strobes, and a registered read-data return. Software programs four registers: the output levels, the per-pin direction, pull enable and pull polarity. It reads back the pin levels through a synchronizer. Two write-only offsets let software set or clear chosen output bits in one write, with no read-modify-write. The block drives the output value, output-enable and pull controls straight to pad logic.

An address window at 0x20 to 0x3F belongs to a neighbouring interrupt-detection block. The port decodes that window and passes each access on through a strobe, a window-relative address and the write data. It returns the neighbour's read data on the normal read path. Every access is decoded into one of a fixed set of named selector values: none, output data, input data, direction, set, clear, pull enable, pull type and forwarded. That selector steers both the register updates and the read multiplexer.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, and during any later reset, pin_out, pin_oe, pull_en, pull_up and bus_rdata are all zero, and every readable register reads as zero.
- R2: A write to offset 0x00 loads the output data register, which drives pin_out from the next clock and reads back at offset 0x00.
- R3: A write to offset 0x10 sets every output data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x14 clears every output data bit whose write-data bit is 1 and leaves the other bits unchanged.
- R5: Offset 0x08 is the direction register, readable and writable. A bit of 1 drives that pin's pin_oe high (output) and a bit of 0 drives it low (input).
- R6: Offset 0x18 (pull enable, driven on pull_en) and offset 0x1C (pull polarity, driven on pull_up, 1 = pull up) are 32-bit read/write registers.
- R7: A read of offset 0x04 returns pin_in after a two-flop synchronizer. With the pins changed just before clock edge 1 and a read held high from that cycle on, the returned data shows the old level after edges 1 and 2 and the new level after edge 3. Writes to 0x04 change no register.
- R8: Reads of 0x10, 0x14, unmapped offsets (0x0C, 0x40 and above) and misaligned addresses (low two bits nonzero) return zero. Writes there change no register.
- R9: An access to 0x20 to 0x3F raises ext_wr or ext_rd in the same cycle, with ext_addr equal to the low five address bits and ext_wdata equal to the write data. A read there returns ext_rdata sampled in the strobe cycle. Accesses outside the window keep ext_wr and ext_rd low.
- R10: bus_rdata updates on the clock edge that ends a cycle with bus_rd high, and is zero after any cycle with bus_rd low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels from the pads |
| pin_out | output | 32 | Output level per pin |
| pin_oe | output | 32 | Output enable per pin, 1 = drive |
| pull_en | output | 32 | Pull resistor enable per pin |
| pull_up | output | 32 | Pull polarity per pin, 1 = up, 0 = down |
| ext_wr | output | 1 | Write strobe forwarded to the interrupt block |
| ext_rd | output | 1 | Read strobe forwarded to the interrupt block |
| ext_addr | output | 5 | Address within the forwarded window |
| ext_wdata | output | 32 | Write data forwarded to the interrupt block |
| ext_rdata | input | 32 | Read data returned by the interrupt block |

## Verification
A wrong selector or register update shows at the pad outputs on the very next clock, because pin_out, pin_oe, pull_en and pull_up come straight from the registers. A stray write to an ignored offset shows the same way. A decode error on the read side shows one clock after the read strobe, as a wrong value or a nonzero value from a write-only offset. A synchronizer with the wrong depth shifts the edge at which a changed pin becomes visible by whole cycles. Back-to-back reads across the change expose that directly.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

    // Word indices (byte offset / 4) of the mapped registers
    localparam int unsigned WIX_DOUT  = 0;
    localparam int unsigned WIX_DIN   = 1;
    localparam int unsigned WIX_DIR   = 2;
    localparam int unsigned WIX_SET   = 4;
    localparam int unsigned WIX_CLR   = 5;
    localparam int unsigned WIX_PEN   = 6;
    localparam int unsigned WIX_PTYPE = 7;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DOUT,
        SEL_DIN,
        SEL_DIR,
        SEL_SET,
        SEL_CLR,
        SEL_PEN,
        SEL_PTYPE,
        SEL_EXT
    } reg_sel_e;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_regs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int EXT_AW = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int WORD_W = ADDR_W - 2;
    localparam int HI_W   = ADDR_W - EXT_AW;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    always_comb begin
        sel = SEL_NONE;
        if (addr[ADDR_W-1:EXT_AW] == HI_W'(1)) begin
            sel = SEL_EXT;
        end else if (addr[1:0] == 2'b00) begin
            unique case (word)
                WORD_W'(WIX_DOUT):  sel = SEL_DOUT;
                WORD_W'(WIX_DIN):   sel = SEL_DIN;
                WORD_W'(WIX_DIR):   sel = SEL_DIR;
                WORD_W'(WIX_SET):   sel = SEL_SET;
                WORD_W'(WIX_CLR):   sel = SEL_CLR;
                WORD_W'(WIX_PEN):   sel = SEL_PEN;
                WORD_W'(WIX_PTYPE): sel = SEL_PTYPE;
                default:            sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int DW     = 32,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] async_in,
    output logic [DW-1:0] sync_out
);
    logic [DW-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
    import gpio_regs_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] dout_q,
    output logic [DW-1:0] dir_q,
    output logic [DW-1:0] pen_q,
    output logic [DW-1:0] ptype_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '0;
            pen_q   <= '0;
            ptype_q <= '0;
        end else if (wr) begin
            unique case (sel)
                SEL_DOUT:  dout_q  <= wdata;
                SEL_SET:   dout_q  <= dout_q | wdata;
                SEL_CLR:   dout_q  <= dout_q & ~wdata;
                SEL_DIR:   dir_q   <= wdata;
                SEL_PEN:   pen_q   <= wdata;
                SEL_PTYPE: ptype_q <= wdata;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_regs_pkg::*;
#(
    parameter int DW          = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int EXT_AW      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DW-1:0]     bus_rdata,
    input  logic [DW-1:0]     pin_in,
    output logic [DW-1:0]     pin_out,
    output logic [DW-1:0]     pin_oe,
    output logic [DW-1:0]     pull_en,
    output logic [DW-1:0]     pull_up,
    output logic              ext_wr,
    output logic              ext_rd,
    output logic [EXT_AW-1:0] ext_addr,
    output logic [DW-1:0]     ext_wdata,
    input  logic [DW-1:0]     ext_rdata
);
    reg_sel_e      sel;
    logic [DW-1:0] din_s;
    logic [DW-1:0] dout_q, dir_q, pen_q, ptype_q;
    logic [DW-1:0] rd_mux;

    gpio_addr_decode #(.ADDR_W(ADDR_W), .EXT_AW(EXT_AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_in_sync #(.DW(DW), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (din_s)
    );

    gpio_out_bank #(.DW(DW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .sel     (sel),
        .wdata   (bus_wdata),
        .dout_q  (dout_q),
        .dir_q   (dir_q),
        .pen_q   (pen_q),
        .ptype_q (ptype_q)
    );

    always_comb begin
        unique case (sel)
            SEL_DOUT:  rd_mux = dout_q;
            SEL_DIN:   rd_mux = din_s;
            SEL_DIR:   rd_mux = dir_q;
            SEL_PEN:   rd_mux = pen_q;
            SEL_PTYPE: rd_mux = ptype_q;
            SEL_EXT:   rd_mux = ext_rdata;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
        else             bus_rdata <= '0;
    end

    assign ext_wr    = bus_wr && (sel == SEL_EXT);
    assign ext_rd    = bus_rd && (sel == SEL_EXT);
    assign ext_addr  = bus_addr[EXT_AW-1:0];
    assign ext_wdata = bus_wdata;

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;
    assign pull_en = pen_q;
    assign pull_up = ptype_q;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int DW     = 32,
    parameter int ADDR_W = 8,
    parameter int EXT_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DW-1:0]     bus_rdata,
    input logic [DW-1:0]     pin_out,
    input logic [DW-1:0]     pin_oe,
    input logic [DW-1:0]     pull_en,
    input logic [DW-1:0]     ext_rdata
);
    localparam int HI_W = ADDR_W - EXT_AW;

    logic hit_dout, hit_set, hit_clr, hit_dir, hit_pen, hit_ext;
    assign hit_dout = bus_addr == ADDR_W'(8'h00);
    assign hit_set  = bus_addr == ADDR_W'(8'h10);
    assign hit_clr  = bus_addr == ADDR_W'(8'h14);
    assign hit_dir  = bus_addr == ADDR_W'(8'h08);
    assign hit_pen  = bus_addr == ADDR_W'(8'h18);
    assign hit_ext  = bus_addr[ADDR_W-1:EXT_AW] == HI_W'(1);

    // R2
    a_r2_load_out: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_dout) |=> pin_out == $past(bus_wdata));

    // R3
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_set) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

    // R4
    a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_clr) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));

    // R5
    a_r5_dir_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_dir) |=> pin_oe == $past(bus_wdata));

    // R6
    a_r6_pull_en: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_pen) |=> pull_en == $past(bus_wdata));

    // R8: output data only moves on its three write offsets
    a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (hit_dout || hit_set || hit_clr)) |=> $stable(pin_out));

    // R9
    a_r9_fwd_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_ext) |=> bus_rdata == $past(ext_rdata));

    // R10
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == '0);

endmodule

bind gpio_port_regs gpio_port_regs_chk #(.DW(DW), .ADDR_W(ADDR_W), .EXT_AW(EXT_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pull_en   (pull_en),
    .ext_rdata (ext_rdata)
);

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pull_en, pull_up;
    logic        ext_wr, ext_rd;
    logic [4:0]  ext_addr;
    logic [31:0] ext_wdata;
    logic [31:0] ext_rdata;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    // Neighbour model: returns a pattern tagged with the window address
    assign ext_rdata = {24'hC0FFEE, 3'b000, ext_addr};

    gpio_port_regs u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pull_en(pull_en), .pull_up(pull_up),
        .ext_wr(ext_wr), .ext_rd(ext_rd), .ext_addr(ext_addr),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    // {op, addr, wdata, expected}; op 1 = write, 2 = read-and-compare
    localparam int NVEC = 21;
    localparam logic [79:0] VEC [NVEC] = '{
        {8'd1, 8'h00, 32'hA5A5_0F0F, 32'h0},           // R2
        {8'd2, 8'h00, 32'h0,         32'hA5A5_0F0F},   // R2
        {8'd1, 8'h10, 32'h0000_F0F0, 32'h0},           // R3
        {8'd2, 8'h00, 32'h0,         32'hA5A5_FFFF},   // R3
        {8'd1, 8'h14, 32'hA000_000F, 32'h0},           // R4
        {8'd2, 8'h00, 32'h0,         32'h05A5_FFF0},   // R4
        {8'd1, 8'h08, 32'hFFFF_0000, 32'h0},           // R5
        {8'd2, 8'h08, 32'h0,         32'hFFFF_0000},   // R5
        {8'd1, 8'h18, 32'h1234_5678, 32'h0},           // R6
        {8'd2, 8'h18, 32'h0,         32'h1234_5678},   // R6
        {8'd1, 8'h1C, 32'h8765_4321, 32'h0},           // R6
        {8'd2, 8'h1C, 32'h0,         32'h8765_4321},   // R6
        {8'd2, 8'h10, 32'h0,         32'h0},           // R8
        {8'd2, 8'h14, 32'h0,         32'h0},           // R8
        {8'd2, 8'h40, 32'h0,         32'h0},           // R8
        {8'd2, 8'h01, 32'h0,         32'h0},           // R8
        {8'd1, 8'h44, 32'hFFFF_FFFF, 32'h0},           // R8
        {8'd1, 8'h02, 32'hFFFF_FFFF, 32'h0},           // R8
        {8'd1, 8'h0C, 32'hFFFF_FFFF, 32'h0},           // R8
        {8'd2, 8'h00, 32'h0,         32'h05A5_FFF0},   // R8
        {8'd2, 8'h30, 32'h0,         32'hC0FF_EE10}    // R9
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] got);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        got = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);
        check("R1 pull_en", pull_en | pull_up, '0);
        check("R1 rdata", bus_rdata, '0);
        rst_n = 1'b1;
        bus_read(8'h08, rd);
        check("R1 dir read", rd, '0);

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][79:72] == 8'd1) begin
                bus_write(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                bus_read(VEC[i][71:64], rd);
                check($sformatf("table[%0d] R2..R9 addr %h", i, VEC[i][71:64]), rd, VEC[i][31:0]);
            end
        end

        // Port-side views of the configuration written above
        check("R4 pin_out", pin_out, 32'h05A5_FFF0);
        check("R5 pin_oe", pin_oe, 32'hFFFF_0000);
        check("R6 pull_en", pull_en, 32'h1234_5678);
        check("R6 pull_up", pull_up, 32'h8765_4321);

        // R10: idle cycle returns zero
        @(posedge clk); #1;
        check("R10 idle rdata", bus_rdata, '0);

        // R7: settle a known pin pattern, then change it and read back to back
        @(negedge clk); pin_in = 32'h1111_2222;
        repeat (3) @(negedge clk);
        pin_in = 32'hDEAD_BEEF; bus_addr = 8'h04; bus_rd = 1'b1;
        @(posedge clk); #1; check("R7 edge1", bus_rdata, 32'h1111_2222);
        @(posedge clk); #1; check("R7 edge2", bus_rdata, 32'h1111_2222);
        @(posedge clk); #1; check("R7 edge3", bus_rdata, 32'hDEAD_BEEF);
        @(negedge clk); bus_rd = 1'b0;
        bus_write(8'h04, 32'h0000_0000);
        bus_read(8'h04, rd);
        check("R7 write ignored din", rd, 32'hDEAD_BEEF);
        bus_read(8'h00, rd);
        check("R7 write ignored dout", rd, 32'h05A5_FFF0);

        // R9: forwarded write strobe and fields
        @(negedge clk);
        bus_addr = 8'h24; bus_wdata = 32'h0BAD_F00D; bus_wr = 1'b1;
        #1;
        check("R9 ext_wr", {31'b0, ext_wr}, 32'h1);
        check("R9 ext_addr", {27'b0, ext_addr}, 32'h4);
        check("R9 ext_wdata", ext_wdata, 32'h0BAD_F00D);
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 32'h0000_00FF; bus_rd = 1'b0;
        #1;
        check("R9 no ext_wr outside", {31'b0, ext_wr}, 32'h0);
        @(negedge clk); bus_wr = 1'b0;
        check("R5 pin_oe rewrite", pin_oe, 32'h0000_00FF);
        @(negedge clk);
        bus_addr = 8'h3C; bus_rd = 1'b1;
        #1;
        check("R9 ext_rd", {31'b0, ext_rd}, 32'h1);
        @(posedge clk); #1;
        check("R9 fwd rdata", bus_rdata, 32'hC0FF_EE1C);
        @(negedge clk); bus_rd = 1'b0;

        // R1: reset during operation
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R1 mid pin_out", pin_out, '0);
        check("R1 mid pin_oe", pin_oe, '0);
        check("R1 mid pulls", pull_en | pull_up, '0);
        @(negedge clk); rst_n = 1'b1;
        bus_read(8'h00, rd);
        check("R1 mid dout read", rd, '0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule